// File: doc/BRIEF.md
# Saturating Rounding Lane Shifter

This block shifts every lane of a 64-bit word by that lane's own signed shift amount. The word is cut into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. A negative amount gives a right shift. A zero or positive amount gives a left shift. Per operation, the caller chooses truncation or rounding for right shifts, and saturation or wrap for left shifts that overflow. The operand can be read as signed, as unsigned, or as signed with a result that must be unsigned.

The shifter is used as one execution lane of a vector datapath. An operation is presented with `in_valid`, and its result appears on the registered outputs one clock later, marked by `out_valid`. A cumulative saturation flag collects every lane that clips. It stays set until `sat_clr` is asserted.

Top module: `lane_qshift`

## Requirements
- R1: `lane_sz` picks the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Lane i occupies bits [i*W +: W] of `opnd` and `result`. Its shift amount is the two's-complement value of bits [i*W +: 8] of `shamt`, and the other bits of the shift lane are ignored.
- R2: `mode` 0 is signed, 2 is signed-to-unsigned, and 1 or 3 is unsigned. A zero or positive amount shifts left. A negative amount shifts right by its magnitude: arithmetically in signed mode, logically otherwise.
- R3: With `rnd_en` high, a right shift by m returns the value shifted by m plus the last bit shifted out, which is bit m-1 of the input. This rounds half up.
- R4: In signed mode, an amount at or below -W gives 0 when rounding. Without rounding it gives the sign fill: all ones for a negative lane and 0 otherwise.
- R5: In unsigned mode, an amount at or below -W without rounding, or at or below -(W+1) with rounding, gives 0. An amount of exactly -W with rounding gives the lane's top bit.
- R6: A left shift by less than W keeps the shifted lane if it is representable: as a W-bit signed value in signed mode, or as a W-bit unsigned value otherwise. If it is not representable and `sat_en` is high, the lane saturates and the flag is set.
- R7: A left shift by W or more gives 0 when the lane is 0 or `sat_en` is low. Otherwise the lane saturates and the flag is set.
- R8: Saturated values are the signed maximum for a non-negative signed lane, the signed minimum for a negative signed lane, and all ones in unsigned mode. With `sat_en` low, overflowing lanes keep their low W bits and the flag is never raised.
- R9: In signed-to-unsigned mode with `sat_en` high, a negative lane gives 0 and sets the flag. In every other case the lane is processed as unsigned.
- R10: `sat_flag` is sticky. `sat_clr` clears it at the next edge, unless a clipping operation is accepted at that same edge, in which case the flag is set.
- R11: `result` and `sat_flag` reflect an operation one clock after `in_valid`, with `out_valid` high for that one cycle. While `in_valid` is low, `result` holds.
- R12: Reset drives `result`, `out_valid` and `sat_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| lane_sz | input | 2 | Lane width select |
| mode | input | 2 | Signed / unsigned / signed-to-unsigned |
| rnd_en | input | 1 | Round right shifts |
| sat_en | input | 1 | Saturate overflowing left shifts |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| opnd | input | 64 | Operand word |
| shamt | input | 64 | Per-lane shift amounts |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shifted word |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions check the timing rules on every cycle. They cover the one-cycle valid latency, the holding of the result, the stickiness and clearing of the flag, the rule that a non-saturating operation never raises the flag, and the clipping of a negative full-width lane in signed-to-unsigned mode. The lane arithmetic can only be shown by the bench's scenarios. That covers the rounding bit, the over-range right shift thresholds that differ between signed and unsigned mode, the exact -W rounding case, fit checks at the lane boundary, and saturation values. The bench compares each of these against a reference model written from the rules.

// File: rtl/lane_qshift.sv
module lane_qshift (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  lane_sz,
  input  logic [1:0]  mode,
  input  logic        rnd_en,
  input  logic        sat_en,
  input  logic        sat_clr,
  input  logic [63:0] opnd,
  input  logic [63:0] shamt,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        sat_flag
);

  function automatic logic [127:0] shr(input logic [127:0] v, input int k, input logic sgn);
    logic signed [127:0] s;
    if (sgn) begin
      s = v;
      s = s >>> k;
      return s;
    end
    return v >> k;
  endfunction

  function automatic logic [64:0] lane_op(input logic [63:0] xin, input logic signed [7:0] sh,
                                          input int w, input logic [1:0] md,
                                          input logic rnd, input logic sat);
    logic [127:0] mask, v, t, r, smax, smin;
    logic sgn, neg, fits, clip, s2u_neg;
    int m;
    sgn     = (md == 2'b00);
    mask    = ~({128{1'b1}} << w);
    neg     = xin[w-1];
    v       = {64'd0, xin} & mask;
    if (sgn && neg) v = v | ~mask;
    smax    = mask >> 1;
    smin    = mask & ~smax;
    r       = '0;
    clip    = 1'b0;
    fits    = 1'b1;
    s2u_neg = (md == 2'b10) && sat && neg;
    if (s2u_neg) begin
      clip = 1'b1;
    end else if (sh < 0) begin
      m = -int'(sh);
      if (m >= w + (sgn ? 0 : int'(rnd))) begin
        r = (sgn && !rnd && neg) ? mask : '0;
      end else if (rnd) begin
        t = shr(v, m - 1, sgn);
        r = shr(t, 1, sgn) + {127'd0, t[0]};
      end else begin
        r = shr(v, m, sgn);
      end
    end else if (int'(sh) < w) begin
      r    = v << int'(sh);
      fits = sgn ? (((r ^ {128{r[w-1]}}) & ~smax) == '0) : ((r & ~mask) == '0);
      clip = sat && !fits;
    end else begin
      clip = sat && (v != '0);
    end
    if (clip && !s2u_neg) r = sgn ? (neg ? smin : smax) : mask;
    return {clip, r[63:0] & mask[63:0]};
  endfunction

  for (genvar g = 0; g < 4; g++) begin : g_sz
    localparam int W = 8 << g;
    localparam int N = 64 / W;
    logic [N-1:0][64:0] lo;
    logic [63:0]        rs;
    logic               cl;
    for (genvar l = 0; l < N; l++) begin : g_ln
      assign lo[l] = lane_op(64'(opnd[l*W +: W]), $signed(shamt[l*W +: 8]), W, mode, rnd_en, sat_en);
    end
    always_comb begin
      rs = '0;
      cl = 1'b0;
      for (int i = 0; i < N; i++) begin
        rs = rs | (lo[i][63:0] << (i * W));
        cl = cl | lo[i][64];
      end
    end
  end

  logic [63:0] sel_res;
  logic        sel_clip;

  always_comb begin
    case (lane_sz)
      2'd0:    begin sel_res = g_sz[0].rs; sel_clip = g_sz[0].cl; end
      2'd1:    begin sel_res = g_sz[1].rs; sel_clip = g_sz[1].cl; end
      2'd2:    begin sel_res = g_sz[2].rs; sel_clip = g_sz[2].cl; end
      default: begin sel_res = g_sz[3].rs; sel_clip = g_sz[3].cl; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= sel_res;
      sat_flag  <= (sat_flag & ~sat_clr) | (in_valid & sel_clip);
    end
  end

  p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !in_valid) |=> !sat_flag);
  p_nosat_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_en && !sat_flag) |=> !sat_flag);
  p_s2u_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && mode == 2'b10 && lane_sz == 2'd3 && opnd[63]) |=> (sat_flag && result == 64'd0));

endmodule

// File: tb/tb_lane_qshift.sv
module tb_lane_qshift;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  lane_sz = '0;
  logic [1:0]  mode = '0;
  logic        rnd_en = 1'b0;
  logic        sat_en = 1'b0;
  logic        sat_clr = 1'b0;
  logic [63:0] opnd = '0;
  logic [63:0] shamt = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        sat_flag;

  int checks = 0;
  int fails = 0;
  bit model_flag = 1'b0;
  logic [63:0] last_res = '0;
  logic [63:0] q_res[$];
  bit          q_flag[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  lane_qshift dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sz(lane_sz), .mode(mode),
                   .rnd_en(rnd_en), .sat_en(sat_en), .sat_clr(sat_clr), .opnd(opnd), .shamt(shamt),
                   .out_valid(out_valid), .result(result), .sat_flag(sat_flag));

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_lane(logic [63:0] x, int sh, int w, int md, bit rnd, bit sat,
                                           output bit clip);
    logic signed [127:0] v, p, one, hi, lo;
    logic [63:0] mask;
    bit s, n;
    s    = (md == 0);
    n    = x[w-1];
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    v    = {64'd0, x & mask};
    if (s && n) v = v - (128'sd1 <<< w);
    one  = 128'sd1;
    clip = 1'b0;
    if (md == 2 && sat && n) begin clip = 1'b1; return 64'd0; end
    if (sh < 0) begin
      if (s && -sh >= w) return rnd ? 64'd0 : (n ? mask : 64'd0);
      if (!s && -sh >= w + int'(rnd)) return 64'd0;
      if (rnd) p = (v + (one <<< (-sh - 1))) >>> (-sh);
      else     p = v >>> (-sh);
      return p[63:0] & mask;
    end
    if (sh < w) begin
      p = v <<< sh;
      if (s) begin hi = (one <<< (w - 1)) - one; lo = -(one <<< (w - 1)); end
      else   begin hi = (one <<< w) - one;        lo = 128'sd0; end
      if (!sat || (p <= hi && p >= lo)) return p[63:0] & mask;
    end else if (!sat || v == 0) begin
      return 64'd0;
    end
    clip = 1'b1;
    if (s) return n ? ((mask >> 1) + 64'd1) & mask : mask >> 1;
    return mask;
  endfunction

  task automatic send(logic [63:0] op, logic [63:0] sv, logic [1:0] lsz, logic [1:0] md,
                      bit rnd, bit sat, bit clr, string tag);
    int w;
    logic [63:0] er;
    bit any, c;
    w   = 8 << lsz;
    er  = '0;
    any = 1'b0;
    for (int l = 0; l < 64 / w; l++) begin
      logic [63:0] lr;
      lr  = ref_lane(op >> (l * w), int'($signed(sv[l*w +: 8])), w, int'(md), rnd, sat, c);
      er  = er | (lr << (l * w));
      any = any | c;
    end
    model_flag = (model_flag & ~clr) | any;
    @(negedge clk);
    in_valid = 1'b1; opnd = op; shamt = sv; lane_sz = lsz; mode = md;
    rnd_en = rnd; sat_en = sat; sat_clr = clr;
    q_res.push_back(er);
    q_flag.push_back(model_flag);
    q_tag.push_back(tag);
    last_res = er;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    opnd = 64'hDEAD_BEEF_0123_4567; shamt = 64'h0101_0101_0101_0101;
    repeat (n) @(negedge clk);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rst_n && out_valid) begin
      if (q_res.size() == 0) begin
        check64("R11 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        logic [63:0] er;
        bit ef;
        string t;
        er = q_res.pop_front();
        ef = q_flag.pop_front();
        t  = q_tag.pop_front();
        check64({t, " result"}, result, er);
        check64({t, " sat_flag R10"}, {63'd0, sat_flag}, {63'd0, ef});
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    check64("R12 reset result", result, 64'd0);
    check64("R12 reset out_valid", {63'd0, out_valid}, 64'd0);
    check64("R12 reset sat_flag", {63'd0, sat_flag}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    send({8{8'h05}}, {8{8'h01}}, 2'd0, 2'd0, 0, 1, 0, "R2 left byte");
    send(64'h80F0_FFF0_0010_7FFE, {8{8'hFE}}, 2'd0, 2'd0, 0, 1, 0, "R2 signed right");
    send(64'h80F0_FFF0_0010_7FFE, {8{8'hFE}}, 2'd0, 2'd1, 0, 1, 0, "R2 unsigned right");
    send({4{16'h0003}}, {4{16'hFF02}}, 2'd1, 2'd1, 0, 1, 0, "R1 high shift bits ignored");
    send(64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FF3F, 2'd3, 2'd1, 0, 1, 0, "R1 64-bit lane");
    send({8{8'h07}}, {8{8'hFF}}, 2'd0, 2'd0, 1, 1, 0, "R3 round up");
    send({8{8'hFD}}, {8{8'hFF}}, 2'd0, 2'd0, 1, 1, 0, "R3 round negative");
    send({2{32'h0000_0006}}, {2{32'h0000_00FE}}, 2'd2, 2'd1, 1, 1, 0, "R3 round half");
    send({8{8'h80}}, {8{8'hF8}}, 2'd0, 2'd0, 0, 1, 0, "R4 sign fill");
    send({8{8'h80}}, {8{8'hF8}}, 2'd0, 2'd0, 1, 1, 0, "R4 round to zero");
    send({4{16'h1234}}, {4{16'h009C}}, 2'd1, 2'd0, 0, 1, 0, "R4 far right positive");
    send({8{8'h80}}, {8{8'hF8}}, 2'd0, 2'd1, 1, 1, 0, "R5 exact -W round");
    send({8{8'h80}}, {8{8'hF7}}, 2'd0, 2'd1, 1, 1, 0, "R5 beyond -W round");
    send({8{8'hFF}}, {8{8'hF8}}, 2'd0, 2'd1, 0, 1, 0, "R5 -W truncate");
    send(64'h8000_0000_0000_0000, 64'h0000_0000_0000_00C0, 2'd3, 2'd1, 1, 1, 0, "R5 64-bit exact -W");
    send({8{8'hC0}}, {8{8'h01}}, 2'd0, 2'd0, 0, 1, 0, "R6 signed fits");
    send({8{8'h40}}, {8{8'h01}}, 2'd0, 2'd0, 0, 1, 0, "R6 signed clip max");
    send({8{8'h9F}}, {8{8'h01}}, 2'd0, 2'd0, 0, 1, 1, "R6 signed clip min with clear");
    send({4{16'h8000}}, {4{16'h0001}}, 2'd1, 2'd1, 0, 1, 0, "R6 unsigned clip");
    send({8{8'h00}}, {8{8'h09}}, 2'd0, 2'd0, 0, 1, 1, "R7 zero stays zero after clear");
    send({8{8'h01}}, {8{8'h09}}, 2'd0, 2'd0, 0, 1, 0, "R7 over-width clip");
    send({8{8'hF0}}, {8{8'h7F}}, 2'd0, 2'd0, 0, 1, 0, "R7 over-width negative");
    send({2{32'h4000_0001}}, {2{32'h0000_0002}}, 2'd2, 2'd0, 0, 0, 1, "R8 wrap after clear");
    send({8{8'h41}}, {8{8'h20}}, 2'd0, 2'd1, 0, 0, 0, "R8 wrap over-width");
    send({8{8'hF0}}, {8{8'h00}}, 2'd0, 2'd2, 0, 1, 0, "R9 negative to unsigned");
    send({8{8'h00}}, {8{8'h00}}, 2'd0, 2'd2, 0, 1, 1, "R10 clear with quiet op");
    send({8{8'hF0}}, {8{8'hFC}}, 2'd0, 2'd2, 0, 0, 0, "R9 no sat treated unsigned");
    send({8{8'h70}}, {8{8'h01}}, 2'd0, 2'd2, 0, 1, 0, "R9 positive unsigned clip");
    send(64'h8000_0000_0000_0001, 64'd0, 2'd3, 2'd2, 0, 1, 1, "R10 clear and clip same cycle");
    idle(3);
    #6;
    check64("R11 result holds while idle", result, last_res);
    check64("R11 out_valid low while idle", {63'd0, out_valid}, 64'd0);
    check64("R10 flag sticky while idle", {63'd0, sat_flag}, {63'd0, model_flag});
    @(negedge clk);
    sat_clr = 1'b1;
    model_flag = 1'b0;
    @(posedge clk);
    #2;
    check64("R10 clear alone", {63'd0, sat_flag}, 64'd0);
    check64("R11 result holds during clear", result, last_res);
    @(negedge clk);
    sat_clr = 1'b0;

    for (int k = 0; k < 400; k++) begin
      logic [1:0]  lsz;
      logic [63:0] op, sv;
      int w;
      lsz = 2'($urandom);
      w   = 8 << lsz;
      op  = {$urandom, $urandom};
      sv  = {$urandom, $urandom};
      for (int l = 0; l < 64 / w; l++) begin
        int pick;
        int amt;
        pick = $urandom % 6;
        case (pick)
          0: amt = -w;
          1: amt = -w - 1;
          2: amt = w;
          3: amt = int'($urandom % 5) - 2;
          4: amt = -int'($urandom % w);
          default: amt = int'($signed(8'($urandom)));
        endcase
        sv[l*w +: 8] = 8'(amt);
        if (($urandom % 8) == 0) op[l*w +: 8] = 8'd0;
      end
      send(op, sv, lsz, 2'($urandom), 1'($urandom), 1'($urandom), (($urandom % 16) == 0),
           "R2 random mix");
      if (($urandom % 10) == 0) idle(1);
    end
    idle(4);
    check64("R11 queue drained", 64'(q_res.size()), 64'd0);
    finish_run();
  end
endmodule